// File: doc/BRIEF.md
# Transport Packet Capture Buffer with Interrupt Control

This block takes a byte stream of fixed-length transport packets, each marked by a start flag on its first byte. It stores up to eight whole packets in a flat capture buffer. Every accepted byte goes out on a write port as an address and a data byte. That port stands in for the bus engine that would move the data to host memory.

A single 32-bit control/status word holds several things:
- a count of the completed packets;
- a buffer-done flag, raised when the count reaches a programmable threshold;
- an overflow flag, raised when a packet arrives while the buffer is full;
- two live status bits, for a nearly full buffer and for the lock signal;
- a mask per status source;
- a write-one acknowledge;
- an active-low run bit that holds the capture logic in reset.

A second register, selected by `reg_sel`, returns the write position to the start of the buffer when it is written. Software arms the block, waits for `irq`, drains the packets, rewinds the buffer and acknowledges.

Top module: `tsbuf_irq_top`

## Requirements
- R1: After `rst_n` low, the control word (reg_sel=0) reads 0x00027004 with `lock_in`=0: the four masks (bits 17, 14, 13, 12) set, run bit 15 clear, threshold bits 6:0 = 4, and both flags and the count zero. `irq` and `wr_en` are 0.
- R2: With run=1, a byte with `in_valid` and `in_sop` opens a packet. That byte and the next 187 valid bytes are each written one cycle after acceptance, at address slot*188 + offset, where slot is the number of packets completed. Valid bytes outside an open packet are not written.
- R3: Bits 31:24 of the control word hold the packet count. It rises by one in the cycle after a packet's 188th byte is accepted, and it never exceeds 8.
- R4: Bit 16 (done) is set in the same cycle that the count becomes equal to the threshold in bits 6:0. Capture carries on into the remaining slots.
- R5: A start byte that arrives while the count is 8 is dropped, along with the rest of its packet: nothing is written. It sets bit 11 (overflow).
- R6: `irq` = (bit16 AND NOT bit17) OR (bit11 AND NOT bit14). It stays high until an acknowledge or a mask write removes it.
- R7: A control-word write with bit 8 = 1 clears bits 16 and 11. A new event in the same cycle wins over the acknowledge. Bit 8 always reads 0.
- R8: While bit 15 is 0, the count, the write position and any open packet stay cleared and the input is ignored. The flags are kept.
- R9: A write with reg_sel=1 sets the count and the write position to zero and closes any open packet. That register reads as 0.
- R10: Bit 10 reads 1 while the count is 7 or more, and bit 9 follows `lock_in`. Neither one raises `irq`, whatever the values of mask bits 13 and 12, which read back as written.
- R11: A start byte that arrives inside an open packet restarts that packet at offset 0 of the same slot.
- R12: A threshold of 0, or one above 8, never sets bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first byte of a packet |
| in_data | input | 8 | Input byte |
| lock_in | input | 1 | Lock status from the receiver, shown in bit 9 |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control/status word, 1 = rewind register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 11 | Buffer byte address |
| wr_data | output | 8 | Buffer byte |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions check the following on every cycle:
- the count cap;
- the range of the buffer address;
- that `irq` holds until a control write;
- that an acknowledge with no coincident event clears both flags;
- that a rewind or a stopped state leaves nothing written;
- that a start byte into a full buffer both sets overflow and suppresses the write.

Only the bench's scenarios can show the exact byte placement across slots, the restart of a packet on a stray start byte, and the ordering of threshold and masks. The same holds for threshold values that can never match, and for the status bits staying out of the interrupt. A cycle-accurate reference model checks these against every output in every cycle.

// File: rtl/tsbuf_pkg.sv
// Package: shared field positions and widths of the control/status word.
// Assumes a 32-bit register port and an 8-bit packet counter field.
package tsbuf_pkg;
    localparam int CNT_W        = 8;
    localparam int THR_W        = 7;
    localparam int CSR_CNT_LSB  = 24;
    localparam int CSR_DONE_MSK = 17;
    localparam int CSR_DONE     = 16;
    localparam int CSR_RUN      = 15;
    localparam int CSR_OVF_MSK  = 14;
    localparam int CSR_AF_MSK   = 13;
    localparam int CSR_LOCK_MSK = 12;
    localparam int CSR_OVF      = 11;
    localparam int CSR_AF       = 10;
    localparam int CSR_LOCK     = 9;
    localparam int CSR_ACK      = 8;

    // Software-written configuration held in the control word
    typedef struct packed {
        logic             done_msk;
        logic             ovf_msk;
        logic             af_msk;
        logic             lock_msk;
        logic             run;
        logic [THR_W-1:0] thr;
    } tsbuf_cfg_t;
endpackage

// File: rtl/tsbuf_pkt_writer.sv
// Packet framer and buffer address generator.
// Opens a packet on a start byte, writes each byte at slot base + offset,
// counts completed packets and reports completion and overflow events
// combinationally, so the flags can update on the same edge as the count.
// Assumes that "clear" (stopped or rewind) takes priority over input bytes.
module tsbuf_pkt_writer #(
    parameter int PKT_BYTES = 188,
    parameter int BUF_PKTS  = 8,
    parameter int ADDR_W    = 11,
    parameter int IDX_W     = 8,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [7:0]        in_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic [CNT_W-1:0]  pkt_cnt,
    output logic              cmpl_evt,
    output logic [CNT_W-1:0]  cnt_next,
    output logic              ovf_evt
);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(PKT_BYTES - 1);
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(BUF_PKTS);
    localparam logic [ADDR_W-1:0] SLOT_SZ  = ADDR_W'(PKT_BYTES);

    logic              in_pkt;
    logic [IDX_W-1:0]  byte_idx;
    logic [ADDR_W-1:0] slot_base;
    logic              clear, full, take_sop, take_body, accept;
    logic [ADDR_W-1:0] byte_addr;

    // Decode what the current input byte does
    always_comb begin
        clear     = !run || restart;
        full      = (pkt_cnt == FULL_CNT);
        take_sop  = !clear && in_valid && in_sop && !full;
        take_body = !clear && in_valid && !in_sop && in_pkt;
        accept    = take_sop || take_body;
        ovf_evt   = !clear && in_valid && in_sop && full;
        cmpl_evt  = take_body && (byte_idx == LAST_IDX);
        cnt_next  = pkt_cnt + CNT_W'(1);
        byte_addr = take_sop ? slot_base : (slot_base + ADDR_W'(byte_idx));
    end

    // Register the buffer write port
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= accept;
            wr_addr <= byte_addr;
            wr_data <= in_data;
        end
    end

    // Track packet framing, slot base and completed count
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            in_pkt    <= 1'b0;
            byte_idx  <= '0;
            slot_base <= '0;
            pkt_cnt   <= '0;
        end else if (ovf_evt) begin
            in_pkt   <= 1'b0;
            byte_idx <= '0;
        end else if (take_sop) begin
            in_pkt   <= 1'b1;
            byte_idx <= IDX_W'(1);
        end else if (take_body) begin
            if (cmpl_evt) begin
                in_pkt    <= 1'b0;
                byte_idx  <= '0;
                slot_base <= slot_base + SLOT_SZ;
                pkt_cnt   <= cnt_next;
            end else begin
                byte_idx <= byte_idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/tsbuf_csr.sv
// Control/status word and rewind register.
// Holds masks, run bit and threshold; latches done and overflow flags
// (set beats acknowledge); assembles read data from live state.
// Assumes one register access per cycle and reads without side effects.
module tsbuf_csr
    import tsbuf_pkg::*;
#(
    parameter int THR_DEFAULT = 4,
    parameter int AF_LEVEL    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [CNT_W-1:0] pkt_cnt,
    input  logic             cmpl_evt,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             ovf_evt,
    input  logic             lock_in,
    output tsbuf_cfg_t       cfg,
    output logic             flag_done,
    output logic             flag_ovf,
    output logic             restart
);
    logic ctrl_wr, ack, done_set, near_full;
    logic unused_wdata;

    assign unused_wdata = ^{reg_wdata[31:18], reg_wdata[7]};

    // Decode writes and flag-set conditions
    always_comb begin
        ctrl_wr   = reg_wr && !reg_sel;
        restart   = reg_wr && reg_sel;
        ack       = ctrl_wr && reg_wdata[CSR_ACK];
        done_set  = cmpl_evt && (cnt_next == CNT_W'(cfg.thr));
        near_full = (pkt_cnt >= CNT_W'(AF_LEVEL));
    end

    // Hold the software configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.done_msk <= 1'b1;
            cfg.ovf_msk  <= 1'b1;
            cfg.af_msk   <= 1'b1;
            cfg.lock_msk <= 1'b1;
            cfg.run      <= 1'b0;
            cfg.thr      <= THR_W'(THR_DEFAULT);
        end else if (ctrl_wr) begin
            cfg.done_msk <= reg_wdata[CSR_DONE_MSK];
            cfg.ovf_msk  <= reg_wdata[CSR_OVF_MSK];
            cfg.af_msk   <= reg_wdata[CSR_AF_MSK];
            cfg.lock_msk <= reg_wdata[CSR_LOCK_MSK];
            cfg.run      <= reg_wdata[CSR_RUN];
            cfg.thr      <= reg_wdata[THR_W-1:0];
        end
    end

    // Latch interrupt flags; a new event wins over acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_done <= 1'b0;
            flag_ovf  <= 1'b0;
        end else begin
            flag_done <= done_set || (flag_done && !ack);
            flag_ovf  <= ovf_evt  || (flag_ovf  && !ack);
        end
    end

    // Assemble read data for the selected register
    always_comb begin
        reg_rdata = '0;
        if (!reg_sel) begin
            reg_rdata[CSR_CNT_LSB +: CNT_W] = pkt_cnt;
            reg_rdata[CSR_DONE_MSK]         = cfg.done_msk;
            reg_rdata[CSR_DONE]             = flag_done;
            reg_rdata[CSR_RUN]              = cfg.run;
            reg_rdata[CSR_OVF_MSK]          = cfg.ovf_msk;
            reg_rdata[CSR_AF_MSK]           = cfg.af_msk;
            reg_rdata[CSR_LOCK_MSK]         = cfg.lock_msk;
            reg_rdata[CSR_OVF]              = flag_ovf;
            reg_rdata[CSR_AF]               = near_full;
            reg_rdata[CSR_LOCK]             = lock_in;
            reg_rdata[THR_W-1:0]            = cfg.thr;
        end
    end
endmodule

// File: rtl/tsbuf_irq_merge.sv
// Interrupt combiner: one masked term per latched source, ORed together.
// Assumes flags are already held until acknowledged.
module tsbuf_irq_merge #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0] flags,
    input  logic [N_SRC-1:0] masks,
    output logic             irq
);
    logic [N_SRC-1:0] live;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // Pass a source only while it is unmasked
        assign live[i] = flags[i] & ~masks[i];
    end

    assign irq = |live;
endmodule

// File: rtl/tsbuf_irq_top.sv
// Top: transport packet capture buffer with interrupt control.
// Connects the framer, the register block and the interrupt combiner.
// Assumes BUF_PKTS fits the 8-bit count field.
module tsbuf_irq_top
    import tsbuf_pkg::*;
#(
    parameter int PKT_BYTES   = 188,
    parameter int BUF_PKTS    = 8,
    parameter int THR_DEFAULT = BUF_PKTS / 2,
    parameter int AF_LEVEL    = BUF_PKTS - 1
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    in_valid,
    input  logic                                    in_sop,
    input  logic [7:0]                              in_data,
    input  logic                                    lock_in,
    input  logic                                    reg_wr,
    input  logic                                    reg_sel,
    input  logic [31:0]                             reg_wdata,
    output logic [31:0]                             reg_rdata,
    output logic                                    wr_en,
    output logic [$clog2(PKT_BYTES*BUF_PKTS)-1:0]   wr_addr,
    output logic [7:0]                              wr_data,
    output logic                                    irq
);
    localparam int BUF_BYTES = PKT_BYTES * BUF_PKTS;
    localparam int ADDR_W    = $clog2(BUF_BYTES);
    localparam int IDX_W     = $clog2(PKT_BYTES);

    tsbuf_cfg_t       cfg;
    logic [CNT_W-1:0] pkt_cnt, cnt_next;
    logic             cmpl_evt, ovf_evt, flag_done, flag_ovf, restart, run;

    assign run = cfg.run;

    tsbuf_pkt_writer #(
        .PKT_BYTES(PKT_BYTES), .BUF_PKTS(BUF_PKTS),
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_writer (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pkt_cnt(pkt_cnt), .cmpl_evt(cmpl_evt), .cnt_next(cnt_next),
        .ovf_evt(ovf_evt)
    );

    tsbuf_csr #(
        .THR_DEFAULT(THR_DEFAULT), .AF_LEVEL(AF_LEVEL)
    ) u_csr (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pkt_cnt(pkt_cnt),
        .cmpl_evt(cmpl_evt), .cnt_next(cnt_next), .ovf_evt(ovf_evt),
        .lock_in(lock_in), .cfg(cfg), .flag_done(flag_done),
        .flag_ovf(flag_ovf), .restart(restart)
    );

    tsbuf_irq_merge #(.N_SRC(2)) u_irq (
        .flags({flag_ovf, flag_done}),
        .masks({cfg.ovf_msk, cfg.done_msk}),
        .irq(irq)
    );
endmodule

// File: rtl/tsbuf_irq_top_chk.sv
// Checker for tsbuf_irq_top, attached by bind below.
module tsbuf_irq_top_chk #(
    parameter int BUF_PKTS  = 8,
    parameter int BUF_BYTES = 1504,
    parameter int ADDR_W    = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sop,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [31:0]       reg_wdata,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              irq,
    input logic [7:0]        pkt_cnt,
    input logic              cmpl_evt,
    input logic              ovf_evt,
    input logic              flag_done,
    input logic              flag_ovf,
    input logic              run
);
    p_wr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < BUF_BYTES));

    p_count_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pkt_cnt) <= BUF_PKTS);

    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pkt_cnt) == BUF_PKTS && in_valid && in_sop && run && !(reg_wr && reg_sel))
        |=> (!wr_en && flag_ovf));

    p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(reg_wr && !reg_sel)) |=> irq);

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata[8] && !cmpl_evt && !ovf_evt)
        |=> (!flag_done && !flag_ovf));

    p_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !wr_en);

    p_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> (pkt_cnt == 8'd0 && !wr_en));
endmodule

bind tsbuf_irq_top tsbuf_irq_top_chk #(
    .BUF_PKTS(BUF_PKTS), .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .irq(irq), .pkt_cnt(pkt_cnt),
    .cmpl_evt(cmpl_evt), .ovf_evt(ovf_evt), .flag_done(flag_done),
    .flag_ovf(flag_ovf), .run(run)
);

// File: tb/tsbuf_irq_top_bench.sv
module tsbuf_irq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, lock_in = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        wr_en, irq;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tsbuf_irq_top u_tsbuf_irq_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .lock_in(lock_in), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
    );

    // Reference model state
    int m_cnt, m_idx, m_inpkt, m_run, m_thr;
    int m_mdone, m_movf, m_maf, m_mlock, m_done, m_ovf;
    int e_we, e_addr, e_data;

    always @(posedge clk) begin : mdl
        int clr, cmpl, oe, ack;
        if (!rst_n) begin
            m_cnt = 0; m_idx = 0; m_inpkt = 0; m_run = 0; m_thr = 4;
            m_mdone = 1; m_movf = 1; m_maf = 1; m_mlock = 1;
            m_done = 0; m_ovf = 0; e_we = 0; e_addr = 0; e_data = 0;
        end else begin
            clr = (m_run == 0 || (reg_wr && reg_sel)) ? 1 : 0;
            cmpl = 0; oe = 0; e_we = 0;
            if (clr == 0 && in_valid) begin
                if (in_sop) begin
                    if (m_cnt == 8) begin
                        oe = 1; m_inpkt = 0;
                    end else begin
                        e_we = 1; e_addr = m_cnt * 188; e_data = in_data;
                        m_idx = 1; m_inpkt = 1;
                    end
                end else if (m_inpkt != 0) begin
                    e_we = 1; e_addr = m_cnt * 188 + m_idx; e_data = in_data;
                    if (m_idx == 187) begin
                        m_cnt++; m_idx = 0; m_inpkt = 0; cmpl = 1;
                    end else begin
                        m_idx++;
                    end
                end
            end
            if (clr != 0) begin
                m_cnt = 0; m_idx = 0; m_inpkt = 0;
            end
            ack = (reg_wr && !reg_sel && reg_wdata[8]) ? 1 : 0;
            m_done = ((cmpl != 0 && m_cnt == m_thr) || (m_done != 0 && ack == 0)) ? 1 : 0;
            m_ovf  = (oe != 0 || (m_ovf != 0 && ack == 0)) ? 1 : 0;
            if (reg_wr && !reg_sel) begin
                m_mdone = reg_wdata[17]; m_run = reg_wdata[15];
                m_movf = reg_wdata[14]; m_maf = reg_wdata[13];
                m_mlock = reg_wdata[12]; m_thr = int'(reg_wdata[6:0]);
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every output with the model, away from the clock edge
    always @(posedge clk) begin : cmp
        logic [31:0] c;
        #5;
        if (!finished) begin
            c = 32'd0;
            c[31:24] = m_cnt[7:0]; c[17] = m_mdone[0]; c[16] = m_done[0];
            c[15] = m_run[0]; c[14] = m_movf[0]; c[13] = m_maf[0];
            c[12] = m_mlock[0]; c[11] = m_ovf[0]; c[10] = (m_cnt >= 7);
            c[9] = lock_in; c[6:0] = m_thr[6:0];
            chk("R2", "wr_en", {31'd0, wr_en}, e_we);
            if (e_we != 0) begin
                chk("R2", "wr_addr", {21'd0, wr_addr}, e_addr);
                chk("R2", "wr_data", {24'd0, wr_data}, e_data);
            end
            chk("R6", "irq", {31'd0, irq},
                ((m_done != 0 && m_mdone == 0) || (m_ovf != 0 && m_movf == 0)) ? 1 : 0);
            if (reg_sel) begin
                chk("R9", "rewind reg read", reg_rdata, 32'd0);
            end else begin
                chk("R3", "count field", {24'd0, reg_rdata[31:24]}, {24'd0, c[31:24]});
                chk("R4", "done bit", {31'd0, reg_rdata[16]}, {31'd0, c[16]});
                chk("R5", "overflow bit", {31'd0, reg_rdata[11]}, {31'd0, c[11]});
                chk("R10", "status bits", {30'd0, reg_rdata[10:9]}, {30'd0, c[10:9]});
                chk("R7", "config and ack bit", reg_rdata & 32'h0002_F1FF, c & 32'h0002_F1FF);
            end
        end
    end

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic send_pkt(input logic [7:0] base, input int len, input bit gap);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (gap && (i % 37) == 5) begin
                in_valid = 1'b0; in_sop = 1'b0; in_data = 8'hEE;
                @(negedge clk);
            end
            in_valid = 1'b1; in_sop = (i == 0); in_data = base + 8'(i);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        #5;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1-all: actual running expected finished");
        summary();
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #5;
        chk("R1", "reset word", reg_rdata, 32'h0002_7004);
        chk("R1", "reset irq", {31'd0, irq}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // stray valid bytes before any start byte (R2)
        @(negedge clk); in_valid = 1'b1; in_data = 8'h55;
        @(negedge clk); in_valid = 1'b0;
        wr_reg(1'b0, 32'h0000_B004);
        for (int p = 0; p < 4; p++) send_pkt(8'(p * 16 + 1), 188, p[0]);
        settle();
        chk("R4", "done at threshold", {31'd0, reg_rdata[16]}, 32'd1);
        chk("R6", "irq on done", {31'd0, irq}, 32'd1);
        for (int p = 4; p < 8; p++) send_pkt(8'(p * 16 + 1), 188, 1'b0);
        settle();
        chk("R3", "count full", {24'd0, reg_rdata[31:24]}, 32'd8);
        chk("R10", "near full", {31'd0, reg_rdata[10]}, 32'd1);
        send_pkt(8'h77, 188, 1'b0);
        settle();
        chk("R5", "overflow set", {31'd0, reg_rdata[11]}, 32'd1);
        chk("R5", "count held", {24'd0, reg_rdata[31:24]}, 32'd8);
        wr_reg(1'b0, 32'h0000_B104);
        settle();
        chk("R7", "flags cleared", {30'd0, reg_rdata[16], reg_rdata[11]}, 32'd0);
        chk("R7", "irq cleared", {31'd0, irq}, 32'd0);
        wr_reg(1'b1, 32'hFFFF_FFFF);
        settle();
        chk("R9", "rewind count", {24'd0, reg_rdata[31:24]}, 32'd0);
        send_pkt(8'h20, 50, 1'b0);
        send_pkt(8'h40, 188, 1'b0);
        settle();
        chk("R11", "restart same slot", {24'd0, reg_rdata[31:24]}, 32'd1);
        wr_reg(1'b0, 32'h0000_3004);
        send_pkt(8'h60, 188, 1'b0);
        settle();
        chk("R8", "stopped count", {24'd0, reg_rdata[31:24]}, 32'd0);
        wr_reg(1'b0, 32'h0000_B000);
        send_pkt(8'h81, 188, 1'b0);
        send_pkt(8'h82, 188, 1'b0);
        settle();
        chk("R12", "threshold zero", {31'd0, reg_rdata[16]}, 32'd0);
        wr_reg(1'b0, 32'h0000_B009);
        for (int p = 0; p < 6; p++) send_pkt(8'(p + 3), 188, 1'b0);
        settle();
        chk("R12", "threshold above depth", {31'd0, reg_rdata[16]}, 32'd0);
        wr_reg(1'b1, 32'd0);
        wr_reg(1'b0, 32'h0002_B001);
        send_pkt(8'h90, 188, 1'b1);
        settle();
        chk("R4", "done while masked", {31'd0, reg_rdata[16]}, 32'd1);
        chk("R6", "masked irq", {31'd0, irq}, 32'd0);
        wr_reg(1'b0, 32'h0000_B001);
        settle();
        chk("R6", "unmasked irq", {31'd0, irq}, 32'd1);
        wr_reg(1'b0, 32'h0000_B101);
        lock_in = 1'b1;
        wr_reg(1'b0, 32'h0000_8001);
        settle();
        chk("R10", "lock bit", {31'd0, reg_rdata[9]}, 32'd1);
        for (int p = 0; p < 6; p++) send_pkt(8'(p + 9), 188, 1'b0);
        settle();
        chk("R10", "near full no irq", {31'd0, irq}, 32'd0);
        chk("R10", "mask readback", {30'd0, reg_rdata[13:12]}, 32'd0);
        summary();
    end
endmodule